// File: doc/BRIEF.md
# Two-Way Slot Mailbox with Link Handshake

The block carries 32-bit slots between a host and an embedded peer controller through two ring buffers, one for each direction. The host reaches four word registers over a simple register bus: a transmit window, its own control/status word, a receive window and a read-only view of the peer's control/status word. Each status word shows that ring's 8-bit free-running read and write pointers and its depth in slots. Software finds the fill level as the write pointer minus the read pointer, modulo 256. The free space is the depth minus that fill. Interrupt enable, status and generate bits let each side raise an event for the other. Reset and ready bits in the same word carry a link handshake.

The peer sees a push/pop port. It pops host-to-peer slots from a head output and pushes peer-to-host slots. It also has level and pulse pins for its ready state, its interrupt enable, raising a host event and acknowledging a host event. While the host holds the link in reset, both rings are empty and every push is dropped.

The link is run by a four-state machine. LNK_DOWN is the state after chip reset and after a failed or withdrawn link. LNK_RESET means the host has requested reset and is waiting for the peer. LNK_ARMED means reset is still requested and the peer shows ready. LNK_UP means the link is ready. The transitions are:
- any state to LNK_RESET when the host writes its status word with the reset bit set;
- LNK_RESET to LNK_ARMED when the peer shows ready;
- LNK_ARMED back to LNK_RESET if the peer withdraws ready;
- LNK_ARMED to LNK_UP on a status write with reset clear and ready set;
- LNK_ARMED to LNK_DOWN on a status write with both clear;
- LNK_RESET to LNK_DOWN on a status write with reset clear;
- LNK_DOWN to LNK_UP on a status write with ready set while the peer is ready;
- LNK_UP to LNK_DOWN when the host writes ready clear or the peer drops ready.

Top module: `mbx_mailbox`

## Requirements
- R1: The word address selects the register: 0 is the host-to-peer transmit window, 1 the host status word, 2 the peer-to-host receive window and 3 the peer status word. Read data appears on `host_rdata_o` in the cycle after the read strobe and holds until the next read. A read of the transmit window returns zero.
- R2: In both status words, bit 0 is interrupt enable, bit 1 is interrupt status, bit 2 is interrupt generate (always reads 0), bit 3 is ready, bit 4 is reset and bit 5 is sticky overflow. Bits 15:8 hold the read pointer, bits 23:16 the write pointer and bits 31:24 the depth in slots. The host word describes the host-to-peer ring and the peer word describes the peer-to-host ring. After chip reset the host word reads depth<<24 and nothing else.
- R3: A host write to the transmit window pushes one slot. If that ring is full and the peer does not pop in the same cycle, the write is dropped, the write pointer holds, and host status bit 5 becomes 1. Writing 1 to bit 5 clears it.
- R4: A host read of the receive window pops the oldest slot. On an empty ring the read returns zero and leaves both pointers unchanged.
- R5: Pointers are 8-bit and wrap through 256. Fill (write minus read, modulo 256) never exceeds the depth.
- R6: Host interrupt status is set only by a `peer_gen_i` pulse and cleared by writing 1 to bit 1. If a set and a clear fall in the same cycle, the set wins. `host_irq_o` is high when enable and status are both 1.
- R7: A host status write with bit 2 set raises the peer's interrupt status, which `peer_ack_i` clears. `peer_irq_o` equals that status ANDed with `peer_ie_i`.
- R8: While the reset bit reads 1, both rings are held at pointer zero and `peer_rst_o` is high. Ready reads 0, pushes are dropped without setting overflow, and the peer-to-host overflow flag is cleared.
- R9: Ready reads 1 only after the peer has shown ready. Clearing reset before the peer is ready returns to the down state with ready 0.
- R10: Host writes to the peer status word have no effect.
- R11: A peer push to a full peer-to-host ring is dropped and sets peer status bit 5. A host pop and a peer push in the same cycle on a full ring both succeed.
- R12: `peer_rdata_o` shows the oldest host-to-peer slot and `peer_avail_o` is high when that ring is not empty. `peer_space_o` is high when the peer-to-host ring is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 2 | Word address of the host register |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 32 | Registered host read data |
| host_irq_o | output | 1 | Host interrupt request |
| peer_rst_o | output | 1 | Link reset requested by host |
| peer_ready_i | input | 1 | Peer shows ready |
| peer_ie_i | input | 1 | Peer interrupt enable |
| peer_gen_i | input | 1 | Peer raises a host event (pulse) |
| peer_ack_i | input | 1 | Peer acknowledges its event (pulse) |
| peer_irq_o | output | 1 | Peer interrupt request |
| peer_pop_i | input | 1 | Peer pops a host-to-peer slot |
| peer_rdata_o | output | 32 | Oldest host-to-peer slot |
| peer_avail_o | output | 1 | Host-to-peer ring not empty |
| peer_push_i | input | 1 | Peer pushes a peer-to-host slot |
| peer_wdata_i | input | 32 | Peer push data |
| peer_space_o | output | 1 | Peer-to-host ring not full |

## Verification
Two pairs of functions can meet in one clock.

The first pair is a host write-one-to-clear of interrupt status and a peer event pulse. The bench drives the status write and `peer_gen_i` on the same edge and expects `host_irq_o` to stay high, because the new event must not be lost.

The second pair is a pop and a push on a full ring. The bench fills the peer-to-host ring, then drives a receive-window read and a peer push on the same edge. It expects the oldest slot back and both pointers advanced by one, with no overflow flag. The next lone push must then set the flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Word addresses on the host register bus
    localparam logic [1:0] WA_TXWIN = 2'd0;
    localparam logic [1:0] WA_HCSR  = 2'd1;
    localparam logic [1:0] WA_RXWIN = 2'd2;
    localparam logic [1:0] WA_PCSR  = 2'd3;

    // Control/status bit positions
    localparam int unsigned CB_IE  = 0;
    localparam int unsigned CB_IS  = 1;
    localparam int unsigned CB_IG  = 2;
    localparam int unsigned CB_RDY = 3;
    localparam int unsigned CB_RST = 4;
    localparam int unsigned CB_OVF = 5;

    // Sticky flag slots
    localparam int unsigned FLG_HOST_IS  = 0;
    localparam int unsigned FLG_PEER_IS  = 1;
    localparam int unsigned FLG_H2P_OVF  = 2;
    localparam int unsigned FLG_P2H_OVF  = 3;
    localparam int unsigned N_FLAGS      = 4;

    typedef enum logic [1:0] {
        LNK_DOWN  = 2'd0,
        LNK_RESET = 2'd1,
        LNK_ARMED = 2'd2,
        LNK_UP    = 2'd3
    } link_state_e;

    typedef struct packed {
        logic [7:0] depth;
        logic [7:0] wptr;
        logic [7:0] rptr;
        logic [7:0] flags;
    } csr_word_t;

endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 3      // 1..7, so fill fits the 8-bit pointer space
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [7:0]        wptr_o,
    output logic [7:0]        rptr_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              drop_o
);
    localparam int         DEPTH   = 1 << DEPTH_LOG2;
    localparam int         IDX_W   = DEPTH_LOG2;
    localparam logic [7:0] DEPTH_P = 8'(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [7:0]        wptr_q, rptr_q;
    logic [7:0]        fill;
    logic              pop_ok, push_ok;

    always_comb fill = wptr_q - rptr_q;

    assign full_o  = (fill == DEPTH_P);
    assign empty_o = (fill == 8'd0);

    // Pop is judged on the old state; a pop in the same cycle frees room for a push.
    assign pop_ok  = pop_i  & ~flush_i & ~empty_o;
    assign push_ok = push_i & ~flush_i & (~full_o | pop_ok);
    assign drop_o  = push_i & ~flush_i & ~push_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wptr_q <= 8'd0;
            rptr_q <= 8'd0;
        end else if (flush_i) begin
            wptr_q <= 8'd0;
            rptr_q <= 8'd0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 8'd1;
            if (pop_ok)  rptr_q <= rptr_q + 8'd1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push_ok) begin
            mem_q[wptr_q[IDX_W-1:0]] <= push_data_i;
        end
    end

    assign head_o = empty_o ? '0 : mem_q[rptr_q[IDX_W-1:0]];
    assign wptr_o = wptr_q;
    assign rptr_o = rptr_q;

endmodule

// File: rtl/mbx_sticky.sv
module mbx_sticky (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // A set in the same cycle as a clear wins, so no event is lost.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/mbx_link_fsm.sv
module mbx_link_fsm
    import mbx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic csr_wr_i,
    input  logic wr_rst_i,
    input  logic wr_rdy_i,
    input  logic peer_ready_i,
    output logic flush_o,
    output logic ready_o
);
    link_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LNK_DOWN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (csr_wr_i && wr_rst_i) begin
            state_d = LNK_RESET;
        end else begin
            unique case (state_q)
                LNK_DOWN: begin
                    if (csr_wr_i && wr_rdy_i && peer_ready_i) state_d = LNK_UP;
                end
                LNK_RESET: begin
                    if (csr_wr_i)          state_d = LNK_DOWN;
                    else if (peer_ready_i) state_d = LNK_ARMED;
                end
                LNK_ARMED: begin
                    if (csr_wr_i)           state_d = wr_rdy_i ? LNK_UP : LNK_DOWN;
                    else if (!peer_ready_i) state_d = LNK_RESET;
                end
                LNK_UP: begin
                    if (csr_wr_i && !wr_rdy_i) state_d = LNK_DOWN;
                    else if (!peer_ready_i)    state_d = LNK_DOWN;
                end
                default: state_d = LNK_DOWN;
            endcase
        end
    end

    always_comb begin
        flush_o = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            LNK_DOWN:  ;
            LNK_RESET: flush_o = 1'b1;
            LNK_ARMED: flush_o = 1'b1;
            LNK_UP:    ready_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [1:0]  host_addr_i,
    input  logic        host_wr_i,
    input  logic [31:0] host_wdata_i,
    input  logic        host_rd_i,
    output logic [31:0] host_rdata_o,
    output logic        host_irq_o,
    output logic        peer_rst_o,
    input  logic        peer_ready_i,
    input  logic        peer_ie_i,
    input  logic        peer_gen_i,
    input  logic        peer_ack_i,
    output logic        peer_irq_o,
    input  logic        peer_pop_i,
    output logic [31:0] peer_rdata_o,
    output logic        peer_avail_o,
    input  logic        peer_push_i,
    input  logic [31:0] peer_wdata_i,
    output logic        peer_space_o
);
    localparam logic [7:0] DEPTH_F = 8'(1 << DEPTH_LOG2);

    logic        hit_tx_wr, hit_hcsr_wr, hit_rx_rd;
    logic        flush, host_ready;
    logic        ie_q;
    logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic        host_is;

    logic [31:0] h2p_head, p2h_head;
    logic [7:0]  h2p_wptr, h2p_rptr, p2h_wptr, p2h_rptr;
    logic        h2p_full, h2p_empty, h2p_drop;
    logic        p2h_full, p2h_empty, p2h_drop;

    csr_word_t   hcsr, pcsr;
    logic [31:0] rd_mux, rdata_q;

    assign hit_tx_wr   = host_wr_i && (host_addr_i == WA_TXWIN);
    assign hit_hcsr_wr = host_wr_i && (host_addr_i == WA_HCSR);
    assign hit_rx_rd   = host_rd_i && (host_addr_i == WA_RXWIN);

    mbx_link_fsm u_link (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .csr_wr_i     (hit_hcsr_wr),
        .wr_rst_i     (host_wdata_i[CB_RST]),
        .wr_rdy_i     (host_wdata_i[CB_RDY]),
        .peer_ready_i (peer_ready_i),
        .flush_o      (flush),
        .ready_o      (host_ready)
    );

    mbx_ring #(.DATA_W(32), .DEPTH_LOG2(DEPTH_LOG2)) u_h2p (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush),
        .push_i      (hit_tx_wr),
        .push_data_i (host_wdata_i),
        .pop_i       (peer_pop_i),
        .head_o      (h2p_head),
        .wptr_o      (h2p_wptr),
        .rptr_o      (h2p_rptr),
        .full_o      (h2p_full),
        .empty_o     (h2p_empty),
        .drop_o      (h2p_drop)
    );

    mbx_ring #(.DATA_W(32), .DEPTH_LOG2(DEPTH_LOG2)) u_p2h (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush),
        .push_i      (peer_push_i),
        .push_data_i (peer_wdata_i),
        .pop_i       (hit_rx_rd),
        .head_o      (p2h_head),
        .wptr_o      (p2h_wptr),
        .rptr_o      (p2h_rptr),
        .full_o      (p2h_full),
        .empty_o     (p2h_empty),
        .drop_o      (p2h_drop)
    );

    // Sticky event and overflow flags
    always_comb begin
        flag_set[FLG_HOST_IS] = peer_gen_i;
        flag_clr[FLG_HOST_IS] = hit_hcsr_wr && host_wdata_i[CB_IS];
        flag_set[FLG_PEER_IS] = hit_hcsr_wr && host_wdata_i[CB_IG];
        flag_clr[FLG_PEER_IS] = peer_ack_i;
        flag_set[FLG_H2P_OVF] = h2p_drop;
        flag_clr[FLG_H2P_OVF] = (hit_hcsr_wr && host_wdata_i[CB_OVF]) || flush;
        flag_set[FLG_P2H_OVF] = p2h_drop;
        flag_clr[FLG_P2H_OVF] = flush;
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        mbx_sticky u_flag (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .q_o    (flag_q[g])
        );
    end

    assign host_is = flag_q[FLG_HOST_IS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          ie_q <= 1'b0;
        else if (hit_hcsr_wr) ie_q <= host_wdata_i[CB_IE];
    end

    // Status word assembly
    always_comb begin
        hcsr              = '0;
        hcsr.depth        = DEPTH_F;
        hcsr.wptr         = h2p_wptr;
        hcsr.rptr         = h2p_rptr;
        hcsr.flags[CB_IE] = ie_q;
        hcsr.flags[CB_IS] = host_is;
        hcsr.flags[CB_RDY]= host_ready;
        hcsr.flags[CB_RST]= flush;
        hcsr.flags[CB_OVF]= flag_q[FLG_H2P_OVF];

        pcsr              = '0;
        pcsr.depth        = DEPTH_F;
        pcsr.wptr         = p2h_wptr;
        pcsr.rptr         = p2h_rptr;
        pcsr.flags[CB_IE] = peer_ie_i;
        pcsr.flags[CB_IS] = flag_q[FLG_PEER_IS];
        pcsr.flags[CB_RDY]= peer_ready_i;
        pcsr.flags[CB_RST]= flush;
        pcsr.flags[CB_OVF]= flag_q[FLG_P2H_OVF];
    end

    always_comb begin
        unique case (host_addr_i)
            WA_TXWIN: rd_mux = 32'd0;
            WA_HCSR:  rd_mux = hcsr;
            WA_RXWIN: rd_mux = p2h_head;
            default:  rd_mux = pcsr;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        rdata_q <= 32'd0;
        else if (host_rd_i) rdata_q <= rd_mux;
    end

    assign host_rdata_o = rdata_q;
    assign host_irq_o   = ie_q & host_is;
    assign peer_rst_o   = flush;
    assign peer_irq_o   = flag_q[FLG_PEER_IS] & peer_ie_i;
    assign peer_rdata_o = h2p_head;
    assign peer_avail_o = ~h2p_empty;
    assign peer_space_o = ~p2h_full;

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
    parameter int DEPTH_LOG2 = 3
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       host_wr_i,
    input logic       host_rd_i,
    input logic [1:0] host_addr_i,
    input logic       peer_gen_i,
    input logic       peer_ready_i,
    input logic       peer_pop_i,
    input logic       host_irq_o,
    input logic       host_is,
    input logic       host_ready,
    input logic       flush,
    input logic [7:0] h2p_wptr,
    input logic [7:0] h2p_rptr,
    input logic       h2p_full,
    input logic [7:0] p2h_rptr,
    input logic       p2h_empty
);
    localparam logic [7:0] DEPTH_C = 8'(1 << DEPTH_LOG2);

    assert_fill_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        8'(h2p_wptr - h2p_rptr) <= DEPTH_C);

    assert_drop_holds_wptr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_wr_i && host_addr_i == 2'd0 && h2p_full && !peer_pop_i && !flush)
        |=> $stable(h2p_wptr));

    assert_empty_read_holds_rptr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd_i && host_addr_i == 2'd2 && p2h_empty && !flush)
        |=> $stable(p2h_rptr));

    assert_is_needs_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_is) |-> $past(peer_gen_i));

    assert_irq_needs_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_irq_o |-> host_is);

    assert_ready_needs_peer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_ready) |-> $past(peer_ready_i));

    assert_flush_zeroes_ptrs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(flush) |-> (h2p_wptr == 8'd0 && h2p_rptr == 8'd0 && p2h_rptr == 8'd0));

endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DEPTH_LOG2(DEPTH_LOG2)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .host_addr_i  (host_addr_i),
    .peer_gen_i   (peer_gen_i),
    .peer_ready_i (peer_ready_i),
    .peer_pop_i   (peer_pop_i),
    .host_irq_o   (host_irq_o),
    .host_is      (host_is),
    .host_ready   (host_ready),
    .flush        (flush),
    .h2p_wptr     (h2p_wptr),
    .h2p_rptr     (h2p_rptr),
    .h2p_full     (h2p_full),
    .p2h_rptr     (p2h_rptr),
    .p2h_empty    (p2h_empty)
);

// File: tb/mbx_mailbox_tb_top.sv
`timescale 1ns/1ps
module mbx_mailbox_tb_top;

    localparam int DL2 = 2;
    localparam logic [31:0] DEP = 32'(1 << DL2) << 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = 32'd0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        host_irq;
    logic        peer_rst;
    logic        peer_ready = 1'b0;
    logic        peer_ie = 1'b0;
    logic        peer_gen = 1'b0;
    logic        peer_ack = 1'b0;
    logic        peer_irq;
    logic        peer_pop = 1'b0;
    logic [31:0] peer_rdata;
    logic        peer_avail;
    logic        peer_push = 1'b0;
    logic [31:0] peer_wdata = 32'd0;
    logic        peer_space;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbx_mailbox #(.DEPTH_LOG2(DL2)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .host_addr_i  (host_addr),
        .host_wr_i    (host_wr),
        .host_wdata_i (host_wdata),
        .host_rd_i    (host_rd),
        .host_rdata_o (host_rdata),
        .host_irq_o   (host_irq),
        .peer_rst_o   (peer_rst),
        .peer_ready_i (peer_ready),
        .peer_ie_i    (peer_ie),
        .peer_gen_i   (peer_gen),
        .peer_ack_i   (peer_ack),
        .peer_irq_o   (peer_irq),
        .peer_pop_i   (peer_pop),
        .peer_rdata_o (peer_rdata),
        .peer_avail_o (peer_avail),
        .peer_push_i  (peer_push),
        .peer_wdata_i (peer_wdata),
        .peer_space_o (peer_space)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic do_peer_push(input logic [31:0] d);
        peer_wdata = d; peer_push = 1'b1;
        @(negedge clk);
        peer_push = 1'b0;
    endtask

    task automatic do_peer_pop(output logic [31:0] d);
        d = peer_rdata;
        peer_pop = 1'b1;
        @(negedge clk);
        peer_pop = 1'b0;
    endtask

    task automatic pulse_ack();
        peer_ack = 1'b1;
        @(negedge clk);
        peer_ack = 1'b0;
    endtask

    function automatic logic [31:0] csr(input logic [7:0] wp, input logic [7:0] rp, input logic [7:0] fl);
        return DEP | {8'd0, wp, rp, fl};
    endfunction

    initial begin
        logic [31:0] v;
        logic [7:0]  wp, rp, pwp, prp;
        wp = 8'd0; rp = 8'd0; pwp = 8'd0; prp = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R2)
        host_read(2'd1, v); check("R2 host word after reset", v, DEP);
        host_read(2'd3, v); check("R2 peer word after reset", v, DEP);
        host_read(2'd2, v); check("R4 empty rx window", v, 32'd0);
        host_read(2'd0, v); check("R1 tx window reads zero", v, 32'd0);
        check("R6 irq low at reset", {31'd0, host_irq}, 32'd0);

        // Reset withdrawn before peer ready (R8, R9)
        host_write(2'd1, 32'h10);
        host_read(2'd1, v); check("R8 reset shown, ready clear", v, csr(0, 0, 8'h10));
        check("R8 peer_rst_o high", {31'd0, peer_rst}, 32'd1);
        host_write(2'd1, 32'h08);
        host_read(2'd1, v); check("R9 no ready without peer", v, DEP);

        // Full handshake (R7, R8, R9)
        peer_ie = 1'b1;
        host_write(2'd1, 32'h14);
        check("R7 peer irq after generate", {31'd0, peer_irq}, 32'd1);
        host_read(2'd1, v); check("R7 generate reads zero", v, csr(0, 0, 8'h10));
        pulse_ack();
        check("R7 peer ack clears", {31'd0, peer_irq}, 32'd0);
        peer_ready = 1'b1;
        @(negedge clk);
        host_write(2'd1, 32'h0C);
        host_read(2'd1, v); check("R9 ready after handshake", v, csr(0, 0, 8'h08));
        check("R8 peer_rst_o released", {31'd0, peer_rst}, 32'd0);
        pulse_ack();
        peer_ie = 1'b0;
        host_read(2'd3, v); check("R2 peer word ready", v, csr(0, 0, 8'h08));

        // Peer word is read-only (R10)
        host_write(2'd3, 32'hFFFF_FFFF);
        host_read(2'd3, v); check("R10 peer word unchanged", v, csr(0, 0, 8'h08));
        host_read(2'd1, v); check("R10 host word unchanged", v, csr(0, 0, 8'h08));

        // Pointer sweep through wrap (R3, R5, R12)
        for (int it = 0; it < 150; it++) begin
            int n;
            n = it % 5;
            for (int k = 0; k < n; k++) host_write(2'd0, 32'hA000_0000 | (it << 4) | k);
            wp = wp + 8'(n);
            host_read(2'd1, v); check("R5 sweep pointer fields", v, csr(wp, rp, 8'h08));
            check("R12 avail flag", {31'd0, peer_avail}, {31'd0, n != 0});
            for (int k = 0; k < n; k++) begin
                do_peer_pop(v);
                check("R12 peer pop order", v, 32'hA000_0000 | (it << 4) | k);
            end
            rp = rp + 8'(n);
        end
        check("R5 pointers wrapped", {24'd0, wp}, 32'd44);

        // Overflow on full transmit ring (R3)
        for (int k = 0; k < 5; k++) host_write(2'd0, 32'hB0 + k);
        host_read(2'd1, v); check("R3 drop sets overflow", v, csr(wp + 8'd4, rp, 8'h28));
        wp = wp + 8'd4;
        host_write(2'd1, 32'h28);
        host_read(2'd1, v); check("R3 overflow cleared", v, csr(wp, rp, 8'h08));
        for (int k = 0; k < 4; k++) begin
            do_peer_pop(v);
            check("R3 kept slots in order", v, 32'hB0 + k);
        end
        rp = rp + 8'd4;

        // Receive ring, empty read, same-cycle pop and push (R4, R11)
        host_read(2'd2, v); check("R4 empty read zero", v, 32'd0);
        host_read(2'd3, v); check("R4 empty read keeps ptrs", v, csr(pwp, prp, 8'h08));
        for (int k = 0; k < 4; k++) do_peer_push(32'hC0 + k);
        pwp = 8'd4;
        check("R12 no space when full", {31'd0, peer_space}, 32'd0);
        host_addr = 2'd2; host_rd = 1'b1; peer_wdata = 32'hC4; peer_push = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; peer_push = 1'b0;
        check("R11 same-cycle pop data", host_rdata, 32'hC0);
        pwp = 8'd5; prp = 8'd1;
        host_read(2'd3, v); check("R11 same-cycle both advance", v, csr(pwp, prp, 8'h08));
        do_peer_push(32'hC5);
        host_read(2'd3, v); check("R11 peer drop sets overflow", v, csr(pwp, prp, 8'h28));
        for (int k = 1; k < 5; k++) begin
            host_read(2'd2, v); check("R4 pop order", v, 32'hC0 + k);
        end
        prp = 8'd5;
        host_read(2'd2, v); check("R4 drained read zero", v, 32'd0);
        host_read(2'd3, v); check("R4 drained ptrs unchanged", v, csr(pwp, prp, 8'h28));

        // Host interrupt (R6)
        host_write(2'd1, 32'h09);
        check("R6 no irq without event", {31'd0, host_irq}, 32'd0);
        peer_gen = 1'b1; @(negedge clk); peer_gen = 1'b0;
        check("R6 irq on event", {31'd0, host_irq}, 32'd1);
        host_read(2'd1, v); check("R6 status bit set", v, csr(wp, rp, 8'h0B));
        host_write(2'd1, 32'h0B);
        check("R6 write-one clears", {31'd0, host_irq}, 32'd0);
        host_addr = 2'd1; host_wdata = 32'h0B; host_wr = 1'b1; peer_gen = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; peer_gen = 1'b0;
        check("R6 set wins over clear", {31'd0, host_irq}, 32'd1);
        host_write(2'd1, 32'h08);
        check("R6 irq masked by enable", {31'd0, host_irq}, 32'd0);
        host_read(2'd1, v); check("R6 status held while masked", v, csr(wp, rp, 8'h0A));
        host_write(2'd1, 32'h0A);

        // Link reset flushes rings (R8)
        host_write(2'd0, 32'hD0);
        host_write(2'd0, 32'hD1);
        host_write(2'd1, 32'h10);
        @(negedge clk);
        host_read(2'd1, v); check("R8 host ptrs zeroed", v, csr(0, 0, 8'h10));
        host_read(2'd3, v); check("R8 peer ptrs zeroed, ovf cleared", v, csr(0, 0, 8'h18));
        check("R8 nothing available", {31'd0, peer_avail}, 32'd0);
        host_write(2'd0, 32'hD2);
        host_read(2'd1, v); check("R8 push dropped in reset", v, csr(0, 0, 8'h10));
        host_write(2'd1, 32'h0C);
        pulse_ack();
        host_read(2'd1, v); check("R9 ready after second handshake", v, csr(0, 0, 8'h08));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule